// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous RAM of 32-bit words whose bus never needs a dead cycle between reads and writes. Every command (address, read/write select, byte strobes, chip selects, advance/load) is captured on a rising clock edge. The data that belongs to the command moves two enabled edges later, in both directions. Read data is driven out of an output register. Write data is picked up from the write-data input two enabled edges after the write command. A read that follows closely behind a write to the same word is served by forwarding, so it sees the new bytes.

A short burst engine lets the host issue one address and then step through four words with the advance input. The step order is either linear or interleaved. A clock-enable input freezes the whole pipeline. An output-enable input gates the drive flag, which stands in for the bidirectional pad.

Top module: `zbt_sram`

## Requirements
- R1: After a synchronous reset (rst_n low at an edge) the pipeline is deselected: drive_o stays low and rdata_o reads zero until a read completes.
- R2: A read accepted at an enabled edge (chip selected, adv_i low, rd_i high) puts the addressed word on rdata_o and raises the internal drive state after the second following enabled edge. Data is therefore valid in the cycle two enabled cycles after the command.
- R3: A write accepted at an enabled edge (chip selected, adv_i low, rd_i low) stores wdata_i as sampled at the second following enabled edge. Active-low strobe bit k of byte_wr_n_i, sampled with the command, enables bits 8k+7:8k. Lanes whose strobe is high keep their old contents.
- R4: Reads and writes issued back to back, in any order and on every cycle, all complete with correct data and no idle cycle.
- R5: A read issued one cycle after a write to the same word returns that write's new bytes in the strobed lanes and the old bytes in the others.
- R6: With burst_lin_i high at the loading command, each advance (adv_i high) adds one to the two low address bits, wrapping within the aligned group of four. The upper address bits stay fixed.
- R7: With burst_lin_i low at the loading command, the n-th beat of a burst (n = 0..3) uses low address bits equal to the start low bits XOR n.
- R8: During an advance, rd_i and the chip selects are ignored. The beat repeats the kind of operation (read, write or deselect) set by the last load.
- R9: A load with the chip not selected is a deselect: it writes nothing, and drive_o is low in the cycle two enabled edges later.
- R10: When clk_en_n_i is high at an edge, that edge changes no state: outputs, memory and burst position are all kept. The pipeline resumes on the next enabled edge.
- R11: oe_n_i high forces drive_o low in the same cycle, and has no effect on pipeline progress or read data.
- R12: The chip counts as selected only when all three bits of cs_n_i are low. Any other pattern is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n_i | input | 1 | Active-low clock enable; high blocks the edge |
| cs_n_i | input | 3 | Active-low chip selects, all low selects |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| rd_i | input | 1 | 1 = read, 0 = write (used on load only) |
| addr_i | input | 6 | Word address |
| byte_wr_n_i | input | 4 | Active-low byte-lane write strobes |
| burst_lin_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n_i | input | 1 | Active-low output enable |
| wdata_i | input | 32 | Write data, sampled two enabled edges after the write command |
| rdata_o | output | 32 | Registered read data |
| drive_o | output | 1 | High while the block would drive the data bus |

## Verification
The hardest situation to reach is a read landing in the one-cycle window where a write to the same word has been accepted but its data is being stored at that very edge. It gets harder when a stalled edge splits the window or a burst walks into the word. The bench builds this with directed write-then-read pairs on one address using partial strobes. It then runs long random mixes over a small address range, with clock-enable stalls and bursts in both orders. A behavioural queue model predicts every cycle's drive flag and read data.

// File: rtl/zbt_pkg.sv
// Shared types for the zero-turnaround SRAM.
// Assumes: the operation code is carried through every pipeline stage.
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } zbt_op_e;
endpackage

// File: rtl/zbt_addr_seq.sv
// Command/burst sequencer: latches a command on a load, and steps the
// burst position on an advance. It presents the stage-1 operation and
// effective address.
// Assumes: AW >= 3; the burst covers an aligned group of 2**BW words.
module zbt_addr_seq #(
    parameter int AW = 6,
    parameter int BW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            adv,
    input  logic            sel,
    input  logic            rd,
    input  logic            lin,
    input  logic [AW-1:0]   addr_in,
    output zbt_pkg::zbt_op_e op_o,
    output logic [AW-1:0]   addr_o
);
    import zbt_pkg::*;

    logic [AW-1:0] base_q;
    logic [BW-1:0] cnt_q;
    logic          lin_q;
    zbt_op_e       op_q;
    logic [BW-1:0] low;

    // Purpose: on load, capture the command and restart the count; on advance, step the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b0;
            op_q   <= OP_NONE;
        end else if (en) begin
            if (!adv) begin
                base_q <= addr_in;
                cnt_q  <= '0;
                lin_q  <= lin;
                op_q   <= sel ? (rd ? OP_RD : OP_WR) : OP_NONE;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // Purpose: form the low address bits in linear or interleaved order.
    always_comb begin
        if (lin_q) low = base_q[BW-1:0] + cnt_q;
        else       low = base_q[BW-1:0] ^ cnt_q;
    end

    assign addr_o = {base_q[AW-1:BW], low};
    assign op_o   = op_q;

    // R6: an advance never leaves the aligned group
    assert_burst_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv) |=> (addr_o[AW-1:BW] == $past(addr_o[AW-1:BW])));

    // R8: an advance keeps the operation kind of the load
    assert_burst_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv) |=> (op_o == $past(op_o)));

    // R6: linear order steps the low bits by one
    assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv && lin_q) |=> (addr_o[BW-1:0] == BW'($past(addr_o[BW-1:0]) + 1'b1)));
endmodule

// File: rtl/zbt_lane_array.sv
// Byte-lane storage: one array per lane, with a per-lane write enable and a
// registered read of the stage-1 address.
// Assumes: a write and a read of the same word at one edge returns the old
// word; the caller forwards the new bytes.
module zbt_lane_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      en,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [LANES-1:0]          wr_lane,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Purpose: store this lane's byte when its strobe is active.
        always_ff @(posedge clk) begin
            if (en && wr_en && wr_lane[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Purpose: register this lane's byte for the stage-1 address.
        always_ff @(posedge clk) begin
            if (en)
                rd_q <= mem[rd_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/zbt_fwd_merge.sv
// Forwarding merge: replaces array bytes with captured write bytes in each
// lane that the colliding write had strobed.
// Assumes: the hit and lane mask were registered at the same edge as the array read.
module zbt_fwd_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    hit,
    input  logic [LANES-1:0]        lane,
    input  logic [LANES*LANE_W-1:0] fwd_data,
    input  logic [LANES*LANE_W-1:0] arr_data,
    output logic [LANES*LANE_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_mux
        assign merged[g*LANE_W +: LANE_W] = (hit && lane[g]) ? fwd_data[g*LANE_W +: LANE_W]
                                                             : arr_data[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/zbt_sram.sv
// Zero-turnaround pipelined SRAM top. The pipeline is: stage 1 (command
// latched), stage 2 (array read plus forward capture; a write in stage 2
// stores wdata_i), then the output register.
// Assumes: all inputs are synchronous to clk, and clk_en_n_i high freezes everything.
module zbt_sram #(
    parameter int AW     = 6,
    parameter int DW     = 32,
    parameter int NCS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n_i,
    input  logic [NCS-1:0]    cs_n_i,
    input  logic              adv_i,
    input  logic              rd_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW/8-1:0]   byte_wr_n_i,
    input  logic              burst_lin_i,
    input  logic              oe_n_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              drive_o
);
    import zbt_pkg::*;

    localparam int LANE_W = 8;
    localparam int LANES  = DW / LANE_W;

    logic             en;
    logic             sel;
    zbt_op_e          s1_op;
    logic [AW-1:0]    s1_addr;
    logic [LANES-1:0] s1_bw_n_q;
    zbt_op_e          s2_op_q;
    logic [AW-1:0]    s2_addr_q;
    logic [LANES-1:0] s2_bw_n_q;
    logic             wr_now;
    logic             fwd_hit_q;
    logic [LANES-1:0] fwd_lane_q;
    logic [DW-1:0]    fwd_data_q;
    logic [DW-1:0]    arr_rd;
    logic [DW-1:0]    merged;
    logic [DW-1:0]    rdata_q;
    logic             out_vld_q;

    assign en     = ~clk_en_n_i;
    assign sel    = ~(|cs_n_i);
    assign wr_now = (s2_op_q == OP_WR);

    zbt_addr_seq #(.AW(AW), .BW(2)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .adv     (adv_i),
        .sel     (sel),
        .rd      (rd_i),
        .lin     (burst_lin_i),
        .addr_in (addr_i),
        .op_o    (s1_op),
        .addr_o  (s1_addr)
    );

    // Purpose: capture the byte strobes beside each command, load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)  s1_bw_n_q <= '1;
        else if (en) s1_bw_n_q <= byte_wr_n_i;
    end

    // Purpose: move the stage-1 command into stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op_q   <= OP_NONE;
            s2_addr_q <= '0;
            s2_bw_n_q <= '1;
        end else if (en) begin
            s2_op_q   <= s1_op;
            s2_addr_q <= s1_addr;
            s2_bw_n_q <= s1_bw_n_q;
        end
    end

    zbt_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
        .clk     (clk),
        .en      (en),
        .wr_en   (wr_now),
        .wr_addr (s2_addr_q),
        .wr_lane (~s2_bw_n_q),
        .wr_data (wdata_i),
        .rd_addr (s1_addr),
        .rd_data (arr_rd)
    );

    // Purpose: capture the write being stored now when a read of the same word is reading the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_hit_q  <= 1'b0;
            fwd_lane_q <= '0;
            fwd_data_q <= '0;
        end else if (en) begin
            fwd_hit_q  <= wr_now && (s1_op == OP_RD) && (s2_addr_q == s1_addr);
            fwd_lane_q <= ~s2_bw_n_q;
            fwd_data_q <= wdata_i;
        end
    end

    zbt_fwd_merge #(.LANES(LANES), .LANE_W(LANE_W)) fwd_i (
        .hit      (fwd_hit_q),
        .lane     (fwd_lane_q),
        .fwd_data (fwd_data_q),
        .arr_data (arr_rd),
        .merged   (merged)
    );

    // Purpose: load the output register when a read leaves stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            out_vld_q <= 1'b0;
        end else if (en) begin
            out_vld_q <= (s2_op_q == OP_RD);
            if (s2_op_q == OP_RD) rdata_q <= merged;
        end
    end

    assign rdata_o = rdata_q;
    assign drive_o = out_vld_q & ~oe_n_i;

    // R2: a read in stage 2 drives at the next enabled edge
    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op_q == OP_RD) |=> out_vld_q);

    // R9: a non-read in stage 2 releases the bus at the next enabled edge
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op_q != OP_RD) |=> !out_vld_q);

    // R10: a blocked edge keeps outputs and pipeline
    assert_blocked_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n_i |=> ($stable(rdata_q) && $stable(out_vld_q) && $stable(s2_op_q) && $stable(s1_addr)));

    // R5: a forward hit only follows a write in stage 2
    assert_fwd_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op_q != OP_WR) |=> !fwd_hit_q);
endmodule

// File: tb/zbt_sram_tb_top.sv
module zbt_sram_tb_top;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n_i = 1'b0;
    logic [2:0]  cs_n_i = 3'b111;
    logic        adv_i = 1'b0;
    logic        rd_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [3:0]  byte_wr_n_i = 4'hF;
    logic        burst_lin_i = 1'b0;
    logic        oe_n_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        drive_o;

    zbt_sram dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_n_i(clk_en_n_i), .cs_n_i(cs_n_i),
        .adv_i(adv_i), .rd_i(rd_i), .addr_i(addr_i), .byte_wr_n_i(byte_wr_n_i),
        .burst_lin_i(burst_lin_i), .oe_n_i(oe_n_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .drive_o(drive_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit checking = 1'b0;
    string cur_req = "R1";

    // Reference model: memory, a two-entry queue of commands in flight, burst state
    typedef struct { int op; int addr; logic [3:0] bw_n; } ent_t;
    ent_t        pipe[$];
    logic [31:0] m_mem [DEPTH];
    int          m_base = 0, m_cnt = 0, m_op = 0;
    bit          m_lin = 1'b0;
    bit          exp_vld = 1'b0;
    logic [31:0] exp_data = '0;
    ent_t        old_e, new_e;
    int          lo;

    always @(posedge clk) begin
        if (!rst_n) begin
            pipe.delete();
            new_e.op = 0; new_e.addr = 0; new_e.bw_n = 4'hF;
            pipe.push_back(new_e);
            pipe.push_back(new_e);
            m_base = 0; m_cnt = 0; m_op = 0; m_lin = 1'b0;
            exp_vld = 1'b0; exp_data = '0;
        end else if (!clk_en_n_i) begin
            old_e = pipe.pop_front();
            if (old_e.op == 2) begin
                for (int l = 0; l < 4; l++)
                    if (!old_e.bw_n[l]) m_mem[old_e.addr][l*8 +: 8] = wdata_i[l*8 +: 8];
            end
            exp_vld = (old_e.op == 1);
            if (old_e.op == 1) exp_data = m_mem[old_e.addr];
            if (!adv_i) begin
                m_base = int'(addr_i); m_cnt = 0; m_lin = burst_lin_i;
                m_op = (cs_n_i == 3'b000) ? (rd_i ? 1 : 2) : 0;
            end else begin
                m_cnt = (m_cnt + 1) % 4;
            end
            lo = m_lin ? (((m_base % 4) + m_cnt) % 4) : ((m_base % 4) ^ m_cnt);
            new_e.op = m_op;
            new_e.addr = (m_base / 4) * 4 + lo;
            new_e.bw_n = byte_wr_n_i;
            pipe.push_back(new_e);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Per-cycle comparison, a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && checking) begin
            chk(drive_o == (exp_vld && !oe_n_i), cur_req, "drive_o", {31'd0, drive_o},
                {31'd0, exp_vld && !oe_n_i});
            chk(rdata_o === exp_data, cur_req, "rdata_o", rdata_o, exp_data);
        end
    end

    task automatic drv(input logic [2:0] cs, input bit rd, input bit adv, input int a,
                       input logic [3:0] bw, input bit lin, input bit oe_n, input bit cen_n);
        @(negedge clk);
        cs_n_i = cs; rd_i = rd; adv_i = adv; addr_i = AW'(a);
        byte_wr_n_i = bw; burst_lin_i = lin; oe_n_i = oe_n; clk_en_n_i = cen_n;
        wdata_i = $urandom;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(3'b111, 1'b1, 1'b0, 0, 4'hF, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state seen at the ports
        @(posedge clk); #(CLK_P/4);
        chk(drive_o == 1'b0, "R1", "drive after reset", {31'd0, drive_o}, 32'd0);
        chk(rdata_o == 32'd0, "R1", "rdata after reset", rdata_o, 32'd0);
        checking = 1'b1;

        // R3: fill the array with whole-word writes
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) drv(3'b000, 1'b0, 1'b0, i, 4'h0, 1'b0, 1'b0, 1'b0);
        idle(3);

        // R2: back-to-back reads
        cur_req = "R2";
        for (int i = 0; i < 8; i++) drv(3'b000, 1'b1, 1'b0, i * 5, 4'hF, 1'b0, 1'b0, 1'b0);
        idle(3);

        // R3: single-lane writes (strobe bit k gates bits 8k+7:8k), then readback
        cur_req = "R3";
        for (int k = 0; k < 4; k++) drv(3'b000, 1'b0, 1'b0, 10 + k, ~(4'h1 << k), 1'b0, 1'b0, 1'b0);
        drv(3'b000, 1'b0, 1'b0, 14, 4'hF, 1'b0, 1'b0, 1'b0);
        idle(2);
        for (int k = 0; k < 5; k++) drv(3'b000, 1'b1, 1'b0, 10 + k, 4'hF, 1'b0, 1'b0, 1'b0);
        idle(3);

        // R4: alternating write/read with no idle cycle
        cur_req = "R4";
        for (int i = 0; i < 40; i++)
            drv(3'b000, i[0], 1'b0, $urandom_range(0, 7), 4'($urandom), 1'b0, 1'b0, 1'b0);
        idle(3);

        // R5: read right behind a partial write to the same word
        cur_req = "R5";
        for (int i = 0; i < 8; i++) begin
            drv(3'b000, 1'b0, 1'b0, 20 + i, 4'(i * 3 + 1), 1'b0, 1'b0, 1'b0);
            drv(3'b000, 1'b1, 1'b0, 20 + i, 4'hF, 1'b0, 1'b0, 1'b0);
        end
        idle(3);

        // R6: linear bursts, read and write
        cur_req = "R6";
        drv(3'b000, 1'b1, 1'b0, 30, 4'hF, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'b000, 1'b1, 1'b1, 0, 4'hF, 1'b1, 1'b0, 1'b0);
        drv(3'b000, 1'b0, 1'b0, 33, 4'h0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'b000, 1'b0, 1'b1, 0, 4'h0, 1'b1, 1'b0, 1'b0);
        drv(3'b000, 1'b1, 1'b0, 33, 4'hF, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'b000, 1'b1, 1'b1, 0, 4'hF, 1'b1, 1'b0, 1'b0);
        idle(3);

        // R7: interleaved bursts, read and write
        cur_req = "R7";
        drv(3'b000, 1'b0, 1'b0, 41, 4'h0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'b000, 1'b0, 1'b1, 0, 4'h0, 1'b0, 1'b0, 1'b0);
        drv(3'b000, 1'b1, 1'b0, 42, 4'hF, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'b000, 1'b1, 1'b1, 0, 4'hF, 1'b0, 1'b0, 1'b0);
        idle(3);

        // R8: advances with rd_i and selects toggled; advance after a deselect
        cur_req = "R8";
        drv(3'b000, 1'b1, 1'b0, 50, 4'hF, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'(i + 1), 1'b0, 1'b1, 0, 4'h0, 1'b1, 1'b0, 1'b0);
        drv(3'b111, 1'b0, 1'b0, 50, 4'h0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'b000, 1'b0, 1'b1, 0, 4'h0, 1'b1, 1'b0, 1'b0);
        drv(3'b000, 1'b1, 1'b0, 50, 4'hF, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) drv(3'b000, 1'b1, 1'b1, 0, 4'hF, 1'b1, 1'b0, 1'b0);
        idle(3);

        // R9 / R12: partial selects act as deselects, writing nothing
        cur_req = "R12";
        for (int p = 1; p < 8; p++) begin
            drv(3'(p), 1'b0, 1'b0, 12, 4'h0, 1'b0, 1'b0, 1'b0);
            drv(3'(p), 1'b1, 1'b0, 12, 4'hF, 1'b0, 1'b0, 1'b0);
        end
        cur_req = "R9";
        drv(3'b000, 1'b1, 1'b0, 12, 4'hF, 1'b0, 1'b0, 1'b0);
        drv(3'b101, 1'b1, 1'b0, 12, 4'hF, 1'b0, 1'b0, 1'b0);
        drv(3'b000, 1'b1, 1'b0, 13, 4'hF, 1'b0, 1'b0, 1'b0);
        idle(3);

        // R10: blocked edges sprinkled through traffic
        cur_req = "R10";
        for (int i = 0; i < 80; i++)
            drv(3'b000, 1'($urandom), 1'b0, $urandom_range(0, 5), 4'($urandom), 1'b0, 1'b0,
                ($urandom_range(0, 2) == 0));
        idle(3);

        // R11: output enable toggled during reads
        cur_req = "R11";
        for (int i = 0; i < 30; i++)
            drv(3'b000, 1'b1, 1'b0, i, 4'hF, 1'b0, 1'($urandom), 1'b0);
        idle(3);

        // R4: long random mix over a small range, bursts and stalls included
        cur_req = "R4";
        for (int i = 0; i < 1500; i++)
            drv(($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000, 1'($urandom),
                ($urandom_range(0, 2) == 0), $urandom_range(0, 9), 4'($urandom),
                1'($urandom), ($urandom_range(0, 6) == 0), ($urandom_range(0, 5) == 0));
        idle(4);

        checking = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule